// File: doc/BRIEF.md
# Power-Down and Wake Interrupt Controller

This block controls how a small microcontroller system enters low power and how it wakes again. Software reaches it through two byte-wide registers on a simple register port. The interrupt register holds a wake-routing bit and an enable/flag pair for each of three peripheral sources: the real-time clock, USB and keypad. The miscellaneous register holds a power-down bit and two plain serial-port control bits.

When routing is off, enabled flagged peripheral sources drive interrupt line 5. The smart-card request drives line 4 and the user pins drive line 0. When software sets the routing bit before it powers down, all of these sources become one wake request. That request raises line 0 only after a fixed stabilization delay, so the clocks have time to settle. Setting the power-down bit turns off the analog enable (oscillator and PLL) after a shorter fixed delay. It also forces every individual power control to its low-power state. A wake request arriving while powered down clears the power-down bit and turns the analog enable back on at once.

Top module: `pwrwake_ctrl`

## Requirements
- R1: After reset both registers read 0x00, `analog_en` is 1, and `irq0`, `irq4`, `irq5` and `pwr_ctl` are 0.
- R2: The interrupt register (`reg_sel`=0) holds routing at bit 7, RTC enable/flag at bits 6/5, USB enable/flag at bits 4/3 and keypad enable/flag at bits 2/1; bit 0 reads 0. A read returns the pre-edge value on `reg_rdata` one cycle after `reg_rd`. Writing 0xFF with all flags clear reads back 0xD4.
- R3: A one-cycle event pulse sets its flag. Writing 0 to a flag bit clears it, writing 1 leaves it unchanged, and an event in the same cycle as a clearing write wins.
- R4: With routing off, `irq5` is the OR over sources of enable AND flag, `irq4` follows `sc_irq`, and `irq0` is the OR of `usr_irq`. Each output is registered one cycle after its inputs or state.
- R5: With routing on, `irq5` and `irq4` are held at 0.
- R6: With routing on, the wake request is flagged-and-enabled sources OR `sc_irq` OR any `usr_irq`. `irq0` rises exactly WAKE_DLY cycles after the first clock edge that samples routing and a wake request together, and stays high while both remain.
- R7: Any read of the interrupt register clears the routing bit. The value read still shows the old routing bit.
- R8: After a write that sets the power-down bit (`reg_sel`=1, bit 7), `analog_en` falls on the SHDN_DLY-th clock edge after the write edge.
- R9: Clearing the power-down bit before the shutdown delay expires keeps `analog_en` high and restarts the count, so a later set again waits the full SHDN_DLY cycles.
- R10: While the power-down bit is set, `pwr_ctl` is forced to all zeros one cycle later, whatever `pwr_req` is. Otherwise `pwr_ctl` follows `pwr_req` one cycle later.
- R11: Bits 6 and 5 of the miscellaneous register are plain read/write bits driving `uart_lpbk` and `ser_sel`.
- R12: RTC events still set their flag during power-down. A routed wake request clears the power-down bit and sets `analog_en` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 interrupt register, 1 miscellaneous register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rtc_evt | input | 1 | RTC event pulse |
| usb_evt | input | 1 | USB event pulse |
| kp_evt | input | 1 | Keypad event pulse |
| sc_irq | input | 1 | Smart-card interrupt request (level) |
| usr_irq | input | NUSR | User pin interrupt requests (level) |
| pwr_req | input | NPWR | Individual power-control requests |
| irq0 | output | 1 | Interrupt line 0 |
| irq4 | output | 1 | Interrupt line 4 |
| irq5 | output | 1 | Interrupt line 5 |
| analog_en | output | 1 | Oscillator/PLL enable |
| pwr_ctl | output | NPWR | Individual power controls after override |
| uart_lpbk | output | 1 | Serial loopback control |
| ser_sel | output | 1 | Serial pin select control |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that event inputs are single-cycle pulses, and that both delay parameters are at least 2. One assertion checks the exclusive strobes directly. The bench drives reads and writes only through tasks that raise one strobe for one cycle. Its random phase draws a single selector that enables at most one strobe. Event pulses are set at a falling edge and cleared at the next one.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // number of peripheral sources in the interrupt register: 0 keypad, 1 USB, 2 RTC
  localparam int NSRC = 3;
  // bit positions that software decodes
  localparam int ROUTE_BIT = 7;
  localparam int PD_BIT    = 7;
  localparam int LPBK_BIT  = 6;
  localparam int SSEL_BIT  = 5;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_COUNT = 2'd1,
    WK_DONE  = 2'd2
  } wk_state_t;
endpackage

// File: rtl/pwc_regs.sv
module pwc_regs
  import pwc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      wdata,
  input  logic [NSRC-1:0] src_evt,
  input  logic            wake,
  output logic            route,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flag,
  output logic            pd,
  output logic            lpbk,
  output logic            ssel,
  output logic [7:0]      rdata
);
  logic       wr_int, wr_misc, rd_int;
  logic [7:0] int_view, misc_view;

  assign wr_int  = wr_en && !sel;
  assign wr_misc = wr_en && sel;
  assign rd_int  = rd_en && !sel;

  always_comb begin
    int_view = '0;
    int_view[ROUTE_BIT] = route;
    for (int i = 0; i < NSRC; i++) begin
      int_view[2*i+2] = en[i];
      int_view[2*i+1] = flag[i];
    end
    misc_view = '0;
    misc_view[PD_BIT]   = pd;
    misc_view[LPBK_BIT] = lpbk;
    misc_view[SSEL_BIT] = ssel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route <= 1'b0;
      pd    <= 1'b0;
      lpbk  <= 1'b0;
      ssel  <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_int)      route <= wdata[ROUTE_BIT];
      else if (rd_int) route <= 1'b0;
      if (wr_misc) begin
        lpbk <= wdata[LPBK_BIT];
        ssel <= wdata[SSEL_BIT];
      end
      if (wake)         pd <= 1'b0;
      else if (wr_misc) pd <= wdata[PD_BIT];
      if (rd_en) rdata <= sel ? misc_view : int_view;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        en[g]   <= 1'b0;
        flag[g] <= 1'b0;
      end else begin
        if (wr_int) en[g] <= wdata[2*g+2];
        if (src_evt[g])                   flag[g] <= 1'b1;
        else if (wr_int && !wdata[2*g+1]) flag[g] <= 1'b0;
      end
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      src_evt[g] |=> flag[g]);
  end

  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // R7
  rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_int |=> !route);
endmodule

// File: rtl/pwc_wake_route.sv
module pwc_wake_route
  import pwc_pkg::*;
#(
  parameter int NUSR     = 8,
  parameter int WAKE_DLY = 512
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            route,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] flag,
  input  logic            sc_irq,
  input  logic [NUSR-1:0] usr_irq,
  output logic            wake,
  output logic            irq0,
  output logic            irq4,
  output logic            irq5
);
  localparam int CW = $clog2(WAKE_DLY);

  wk_state_t st;
  logic [CW-1:0] cnt;
  logic periph, req;

  assign periph = |(en & flag);
  assign req    = periph || sc_irq || (|usr_irq);
  assign wake   = route && req;

  always_ff @(posedge clk) begin
    if (rst || !route) begin
      st  <= WK_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        WK_IDLE: if (req) begin
          st  <= WK_COUNT;
          cnt <= CW'(1);
        end
        WK_COUNT: begin
          if (cnt == CW'(WAKE_DLY - 1)) st <= WK_DONE;
          else                          cnt <= cnt + 1'b1;
        end
        default: st <= WK_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0 <= 1'b0;
      irq4 <= 1'b0;
      irq5 <= 1'b0;
    end else begin
      irq5 <= !route && periph;
      irq4 <= !route && sc_irq;
      irq0 <= route ? (st == WK_DONE && req) : (|usr_irq);
    end
  end

  // R5
  route_mask_chk: assert property (@(posedge clk) disable iff (rst)
    route |=> (!irq5 && !irq4));

  // R6
  early_irq0_chk: assert property (@(posedge clk) disable iff (rst)
    (route && st == WK_IDLE) |=> !irq0);
endmodule

// File: rtl/pwc_shutdown.sv
module pwc_shutdown #(
  parameter int NPWR     = 4,
  parameter int SHDN_DLY = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd,
  input  logic            wake,
  input  logic [NPWR-1:0] pwr_req,
  output logic            analog_en,
  output logic [NPWR-1:0] pwr_ctl
);
  localparam int SW = $clog2(SHDN_DLY);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      analog_en <= 1'b1;
      cnt       <= '0;
      pwr_ctl   <= '0;
    end else begin
      pwr_ctl <= pd ? '0 : pwr_req;
      if (wake) begin
        analog_en <= 1'b1;
        cnt       <= '0;
      end else if (pd) begin
        if (cnt == SW'(SHDN_DLY - 1)) analog_en <= 1'b0;
        else                          cnt <= cnt + 1'b1;
      end else begin
        analog_en <= 1'b1;
        cnt       <= '0;
      end
    end
  end

  // R8
  an_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(analog_en) |-> $past(pd));

  // R10
  pwr_force_chk: assert property (@(posedge clk) disable iff (rst)
    pd |=> (pwr_ctl == '0));

  // R12
  wake_on_chk: assert property (@(posedge clk) disable iff (rst)
    wake |=> analog_en);
endmodule

// File: rtl/pwrwake_ctrl.sv
module pwrwake_ctrl
  import pwc_pkg::*;
#(
  parameter int NUSR     = 8,
  parameter int NPWR     = 4,
  parameter int WAKE_DLY = 512,
  parameter int SHDN_DLY = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            rtc_evt,
  input  logic            usb_evt,
  input  logic            kp_evt,
  input  logic            sc_irq,
  input  logic [NUSR-1:0] usr_irq,
  input  logic [NPWR-1:0] pwr_req,
  output logic            irq0,
  output logic            irq4,
  output logic            irq5,
  output logic            analog_en,
  output logic [NPWR-1:0] pwr_ctl,
  output logic            uart_lpbk,
  output logic            ser_sel
);
  logic            route, pd, wake;
  logic [NSRC-1:0] en, flag, evt;

  assign evt = {rtc_evt, usb_evt, kp_evt};

  pwc_regs u_regs (
    .clk(clk), .rst(rst), .sel(reg_sel), .wr_en(reg_wr), .rd_en(reg_rd),
    .wdata(reg_wdata), .src_evt(evt), .wake(wake), .route(route),
    .en(en), .flag(flag), .pd(pd), .lpbk(uart_lpbk), .ssel(ser_sel),
    .rdata(reg_rdata)
  );

  pwc_wake_route #(.NUSR(NUSR), .WAKE_DLY(WAKE_DLY)) u_route (
    .clk(clk), .rst(rst), .route(route), .en(en), .flag(flag),
    .sc_irq(sc_irq), .usr_irq(usr_irq), .wake(wake),
    .irq0(irq0), .irq4(irq4), .irq5(irq5)
  );

  pwc_shutdown #(.NPWR(NPWR), .SHDN_DLY(SHDN_DLY)) u_shdn (
    .clk(clk), .rst(rst), .pd(pd), .wake(wake), .pwr_req(pwr_req),
    .analog_en(analog_en), .pwr_ctl(pwr_ctl)
  );
endmodule

// File: tb/tb_pwrwake_ctrl.sv
module tb_pwrwake_ctrl;
  localparam int CLK_NS = 10;
  localparam int W  = 512;
  localparam int S  = 32;
  localparam int NU = 8;
  localparam int NP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic [2:0] evt = '0;  // 2 RTC, 1 USB, 0 keypad
  logic sc = 1'b0;
  logic [NU-1:0] usr = '0;
  logic [NP-1:0] preq = '0;
  logic irq0, irq4, irq5, analog_en, uart_lpbk, ser_sel;
  logic [NP-1:0] pwr_ctl;

  int errs = 0, checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwrwake_ctrl #(.NUSR(NU), .NPWR(NP), .WAKE_DLY(W), .SHDN_DLY(S)) dut (
    .clk(clk), .rst(rst), .reg_sel(sel), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wd), .reg_rdata(rdata), .rtc_evt(evt[2]), .usb_evt(evt[1]),
    .kp_evt(evt[0]), .sc_irq(sc), .usr_irq(usr), .pwr_req(preq),
    .irq0(irq0), .irq4(irq4), .irq5(irq5), .analog_en(analog_en),
    .pwr_ctl(pwr_ctl), .uart_lpbk(uart_lpbk), .ser_sel(ser_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, updated at each rising edge from pre-edge values
  bit m_route, m_pd, m_lp, m_ss, m_i5, m_i4, m_i0, m_an, m_live;
  bit [2:0] m_en, m_fl;
  bit [7:0] m_rd;
  bit [NP-1:0] m_pw;
  int m_sd, m_wk;

  always @(posedge clk) begin : model
    bit req, wake;
    bit [7:0] iv;
    if (rst) begin
      m_route = 0; m_pd = 0; m_lp = 0; m_ss = 0; m_en = 0; m_fl = 0; m_rd = 0;
      m_i5 = 0; m_i4 = 0; m_i0 = 0; m_an = 1; m_pw = 0; m_sd = 0; m_wk = -1;
      m_live = 1;
    end else begin
      req  = ((m_en & m_fl) != 0) || sc || (usr != 0);
      wake = m_route && req;
      iv = {m_route, m_en[2], m_fl[2], m_en[1], m_fl[1], m_en[0], m_fl[0], 1'b0};
      if (rd) m_rd = sel ? {m_pd, m_lp, m_ss, 5'b0} : iv;
      m_i5 = !m_route && ((m_en & m_fl) != 0);
      m_i4 = !m_route && sc;
      m_i0 = m_route ? (req && m_wk >= W) : (usr != 0);
      m_pw = m_pd ? '0 : preq;
      if (wake)      begin m_an = 1; m_sd = 0; end
      else if (m_pd) begin m_sd++; m_an = (m_sd < S); end
      else           begin m_sd = 0; m_an = 1; end
      if (!m_route)      m_wk = -1;
      else if (m_wk < 0) m_wk = req ? 1 : -1;
      else if (m_wk < W) m_wk++;
      for (int i = 0; i < 3; i++) begin
        if (wr && !sel) begin
          m_en[i] = wd[2*i+2];
          if (!wd[2*i+1]) m_fl[i] = 0;
        end
        if (evt[i]) m_fl[i] = 1;
      end
      if (wr && !sel)      m_route = wd[7];
      else if (rd && !sel) m_route = 0;
      if (wr && sel) begin m_pd = wd[7]; m_lp = wd[6]; m_ss = wd[5]; end
      if (wake) m_pd = 0;
    end
  end

  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk("R2 rdata vs model", rdata, m_rd);
      chk("R4 irq5 vs model", irq5, m_i5);
      chk("R5 irq4 vs model", irq4, m_i4);
      chk("R6 irq0 vs model", irq0, m_i0);
      chk("R8 analog_en vs model", analog_en, m_an);
      chk("R10 pwr_ctl vs model", pwr_ctl, m_pw);
      chk("R11 serial bits vs model", {uart_lpbk, ser_sel}, {m_lp, m_ss});
    end
  end

  task automatic wr_reg(input bit s, input logic [7:0] d);
    @(negedge clk); sel = s; wd = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input bit s, output logic [7:0] v);
    @(negedge clk); sel = s; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); evt[i] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 analog_en", analog_en, 1);
    chk("R1 irqs", {irq0, irq4, irq5}, 0);
    chk("R1 pwr_ctl", pwr_ctl, 0);
    rd_reg(0, v); chk("R1 int reg", v, 8'h00);
    rd_reg(1, v); chk("R1 misc reg", v, 8'h00);

    // R2 layout, R7 clear on read
    wr_reg(0, 8'hFF);
    rd_reg(0, v); chk("R2 write FF reads D4", v, 8'hD4);
    rd_reg(0, v); chk("R7 route cleared by read", v, 8'h54);

    // R3 / R4 flags and irq5
    pulse(2);
    @(negedge clk); chk("R4 irq5 from rtc", irq5, 1);
    rd_reg(0, v); chk("R3 rtc flag set", v, 8'h74);
    wr_reg(0, 8'h54);
    rd_reg(0, v); chk("R3 rtc flag cleared", v, 8'h54);
    @(negedge clk); chk("R4 irq5 low after clear", irq5, 0);
    pulse(1);
    wr_reg(0, 8'h5C);
    rd_reg(0, v); chk("R3 writing 1 keeps usb flag", v, 8'h5C);
    wr_reg(0, 8'h54);
    usr = 8'h10;
    repeat (2) @(negedge clk); chk("R4 irq0 follows usr", irq0, 1);
    usr = '0;
    sc = 1'b1;
    repeat (2) @(negedge clk); chk("R4 irq4 follows sc", irq4, 1);

    // R5 / R6 routed wake delay
    wr_reg(0, 8'hD4);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) chk("R5 irq4/irq5 masked", {irq4, irq5}, 0);
    end while (!irq0 && n < 2000);
    chk("R6 wake delay cycles", n, W + 1);
    sc = 1'b0;
    rd_reg(0, v); chk("R7 read shows old route", v[7], 1);
    rd_reg(0, v); chk("R7 route now clear", v[7], 0);

    // R8 / R10 power-down
    preq = 4'hF;
    wr_reg(1, 8'h80);
    n = 0;
    while (analog_en && n < 200) begin @(negedge clk); n++; end
    chk("R8 shutdown delay cycles", n, S);
    chk("R10 pwr_ctl forced low", pwr_ctl, 0);
    rd_reg(1, v); chk("R8 pd bit reads", v, 8'h80);

    // R9 cancel and reload
    wr_reg(1, 8'h00);
    @(negedge clk); chk("R9 analog back on", analog_en, 1);
    chk("R10 pwr_ctl follows req", pwr_ctl, 4'hF);
    wr_reg(1, 8'h80);
    repeat (10) @(negedge clk);
    wr_reg(1, 8'h00);
    bad = 0;
    repeat (S + 5) begin @(negedge clk); if (!analog_en) bad++; end
    chk("R9 analog held after cancel", bad, 0);
    wr_reg(1, 8'h80);
    n = 0;
    while (analog_en && n < 200) begin @(negedge clk); n++; end
    chk("R9 full delay after reload", n, S);

    // R12 wake from power-down by RTC
    wr_reg(0, 8'hC0);
    chk("R12 still powered down", analog_en, 0);
    pulse(2);
    @(negedge clk); chk("R12 analog on at wake", analog_en, 1);
    rd_reg(1, v); chk("R12 pd bit cleared", v[7], 0);
    rd_reg(0, v);
    wr_reg(0, 8'h00);

    // R11 serial control bits
    wr_reg(1, 8'h60);
    chk("R11 both bits set", {uart_lpbk, ser_sel}, 2'b11);
    rd_reg(1, v); chk("R11 readback", v, 8'h60);
    wr_reg(1, 8'h20);
    chk("R11 only ser_sel", {uart_lpbk, ser_sel}, 2'b01);

    // random phase, compared against the model every cycle
    repeat (6000) begin
      int r;
      @(negedge clk);
      evt[0] = ($urandom % 16) == 0;
      evt[1] = ($urandom % 16) == 0;
      evt[2] = ($urandom % 16) == 0;
      if (($urandom % 64) == 0) sc = ~sc;
      if (($urandom % 64) == 0) usr = (($urandom % 2) == 0) ? '0 : NU'($urandom);
      preq = NP'($urandom);
      r = $urandom % 16;
      wr = (r == 0);
      rd = (r == 1);
      sel = $urandom % 2;
      wd = 8'($urandom);
    end
    @(negedge clk);
    evt = '0; wr = 1'b0; rd = 1'b0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule